// File: doc/BRIEF.md
# Miss Target Drain with Critical-Word Completion Timing

This block sits beside one miss-tracking entry of a cache. While the miss is outstanding, requests that hit the same line are parked in a small in-order queue. Each queued target holds a command, a byte offset inside the line, a byte count and, for stores, the write bytes. When the refill line comes back, together with two time stamps (the time the first word arrived and the time the whole line finished), the block walks the queue one target per cycle. It answers each target with a response that carries a completion time and, for loads, the requested bytes. Store bytes are merged into the held line.

Completion timing follows critical-word-first delivery. The head target at refill time sets a reference offset. Every target's distance from it is taken modulo the line size. A target at distance zero is stamped with the first-word time and every other target with the finish time. An invalidate target in the queue kills the line in the middle of the walk. A target that the line can no longer satisfy halts the walk and stays queued, together with everything behind it, for a later refill. The resulting line image and its state bits are presented at the ports for the tag/data store outside the block. Extra hit latency is added outside the block.

Top module: `mshr_target_drain`

## Requirements
- R1: A target is accepted on `tq_push` only while `tq_ready` is high. `tq_ready` is high only when the block is idle, the queue holds fewer than DEPTH entries and `fill_valid` is low. `tq_count` gives the number of queued targets. Pushes made while `tq_ready` is low are dropped.
- R2: On an accepted refill, the offset of the target then at the head of the queue becomes the reference. Each target's distance is (offset − reference) modulo BLK_BYTES, so a negative difference wraps by adding the line size.
- R3: A response for a target at distance zero carries `fill_first_time`. A response for any other distance carries `fill_finish_time`.
- R4: Targets are serviced strictly in queue order, with at most one response per cycle. Each serviced target is removed, so `tq_count` drops by one with every response.
- R5: Command encoding is 0 = read, 1 = write, 2 = invalidate; code 3 is treated as a read. An invalidate target clears `line_valid`, `line_writable` and `line_resv`. It is removed without a response, and the walk goes on to the next target.
- R6: The walk stops at a write target when the line is not both valid and writable, and at a read target when the line is not valid. That target and the targets behind it stay queued, in order, for the next refill.
- R7: A serviced write sets `line_dirty` and replaces line bytes offset .. offset+size−1 with `tq_wdata` bytes 0 .. size−1 (byte k of the word is bits 8k+7:8k). Its response carries zero data.
- R8: A serviced read responds with line bytes offset .. offset+size−1 in word bytes 0 .. size−1. Word bytes at or beyond the size, or beyond the line end, are zero. The size field counts bytes, from 1 to WORD_BYTES.
- R9: A serviced read with `tq_locked` set raises `line_resv`. A new refill clears it.
- R10: A refill loads `fill_data`, `fill_readable` and `fill_writable` into the line and clears dirty. When the queue empties or the walk stops, `done` is high for exactly one cycle, and the block then accepts pushes again. A refill with an empty queue yields `done` and no response.
- R11: After reset the queue is empty, `tq_ready` is high, and `rsp_valid`, `done`, `line_valid`, `line_writable`, `line_dirty` and `line_resv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_push | input | 1 | Enqueue a target |
| tq_cmd | input | 2 | Target command: 0 read, 1 write, 2 invalidate |
| tq_locked | input | 1 | Read places a load-locked reservation |
| tq_offset | input | log2(BLK_BYTES) | Byte offset in the line |
| tq_size | input | log2(WORD_BYTES)+1 | Byte count, 1..WORD_BYTES |
| tq_wdata | input | WORD_BYTES*8 | Store bytes |
| tq_ready | output | 1 | Push will be accepted |
| tq_count | output | log2(DEPTH+1) | Queued targets |
| fill_valid | input | 1 | Refill arrives (taken when idle) |
| fill_data | input | BLK_BYTES*8 | Refill line |
| fill_readable | input | 1 | Refilled line is valid |
| fill_writable | input | 1 | Refilled line is writable |
| fill_first_time | input | TIME_W | First-word arrival time |
| fill_finish_time | input | TIME_W | Whole-line finish time |
| rsp_valid | output | 1 | A response is presented |
| rsp_cmd | output | 2 | Command of the answered target |
| rsp_offset | output | log2(BLK_BYTES) | Offset of the answered target |
| rsp_time | output | TIME_W | Completion time |
| rsp_data | output | WORD_BYTES*8 | Read bytes, zero for writes |
| line_data | output | BLK_BYTES*8 | Current line image |
| line_valid | output | 1 | Line valid |
| line_writable | output | 1 | Line writable |
| line_dirty | output | 1 | Line modified |
| line_resv | output | 1 | Load-locked reservation held |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
A wrong reference offset, or a distance that does not wrap, shows up on the very first response of a walk whose targets lie on both sides of the head offset: the first-word and finish stamps are swapped. A corrupted head pointer or a missed pop changes the response order or leaves `tq_count` off by one once `done` pulses. Stale line permission bits surface one cycle after an invalidate target: the walk either halts too early, with too few responses and a high count, or answers a target it should have left queued. A sweep over every pair of reference and target offset covers the whole distance space.

// File: rtl/mshr_target_drain.sv
module mshr_target_drain #(
  parameter int BLK_BYTES  = 16,
  parameter int WORD_BYTES = 4,
  parameter int DEPTH      = 4,
  parameter int TIME_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tq_push,
  input  logic [1:0]                        tq_cmd,
  input  logic                              tq_locked,
  input  logic [$clog2(BLK_BYTES)-1:0]      tq_offset,
  input  logic [$clog2(WORD_BYTES):0]       tq_size,
  input  logic [WORD_BYTES*8-1:0]           tq_wdata,
  output logic                              tq_ready,
  output logic [$clog2(DEPTH+1)-1:0]        tq_count,
  input  logic                              fill_valid,
  input  logic [BLK_BYTES*8-1:0]            fill_data,
  input  logic                              fill_readable,
  input  logic                              fill_writable,
  input  logic [TIME_W-1:0]                 fill_first_time,
  input  logic [TIME_W-1:0]                 fill_finish_time,
  output logic                              rsp_valid,
  output logic [1:0]                        rsp_cmd,
  output logic [$clog2(BLK_BYTES)-1:0]      rsp_offset,
  output logic [TIME_W-1:0]                 rsp_time,
  output logic [WORD_BYTES*8-1:0]           rsp_data,
  output logic [BLK_BYTES*8-1:0]            line_data,
  output logic                              line_valid,
  output logic                              line_writable,
  output logic                              line_dirty,
  output logic                              line_resv,
  output logic                              done
);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int SZ_W   = $clog2(WORD_BYTES) + 1;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LINE_W = BLK_BYTES * 8;
  localparam int WORD_W = WORD_BYTES * 8;
  localparam logic [1:0] CMD_WR  = 2'd1;
  localparam logic [1:0] CMD_INV = 2'd2;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_DONE} state_t;
  state_t state;

  logic [1:0]        q_cmd    [DEPTH];
  logic              q_locked [DEPTH];
  logic [OFF_W-1:0]  q_off    [DEPTH];
  logic [SZ_W-1:0]   q_size   [DEPTH];
  logic [WORD_W-1:0] q_wdata  [DEPTH];

  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [OFF_W-1:0]  ref_off;
  logic [TIME_W-1:0] first_q, finish_q;

  logic [1:0]        h_cmd;
  logic              h_locked;
  logic [OFF_W-1:0]  h_off, h_dist;
  logic [SZ_W-1:0]   h_size;
  logic [WORD_W-1:0] h_wdata;
  logic [LINE_W-1:0] merged;
  logic [WORD_W-1:0] rd_word;
  logic              push_ok, is_wr, is_inv, can_serve;

  assign h_cmd    = q_cmd[head];
  assign h_locked = q_locked[head];
  assign h_off    = q_off[head];
  assign h_size   = q_size[head];
  assign h_wdata  = q_wdata[head];
  assign h_dist   = h_off - ref_off;

  assign tq_ready = (state == S_IDLE) && (count != FULL_CNT) && !fill_valid;
  assign push_ok  = tq_push && tq_ready;
  assign tq_count = count;
  assign done     = (state == S_DONE);

  assign is_wr     = (h_cmd == CMD_WR);
  assign is_inv    = (h_cmd == CMD_INV);
  assign can_serve = is_wr ? (line_valid && line_writable) : line_valid;

  always_comb begin
    merged = line_data;
    for (int b = 0; b < BLK_BYTES; b++) begin
      int rel;
      rel = b - int'(h_off);
      if (rel >= 0 && rel < int'(h_size) && rel < WORD_BYTES)
        merged[b*8 +: 8] = h_wdata[rel*8 +: 8];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < WORD_BYTES; i++) begin
      int idx;
      idx = int'(h_off) + i;
      if (i < int'(h_size) && idx < BLK_BYTES)
        rd_word[i*8 +: 8] = line_data[idx*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      q_cmd[tail]    <= tq_cmd;
      q_locked[tail] <= tq_locked;
      q_off[tail]    <= tq_offset;
      q_size[tail]   <= tq_size;
      q_wdata[tail]  <= tq_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      head          <= '0;
      tail          <= '0;
      count         <= '0;
      ref_off       <= '0;
      first_q       <= '0;
      finish_q      <= '0;
      line_data     <= '0;
      line_valid    <= 1'b0;
      line_writable <= 1'b0;
      line_dirty    <= 1'b0;
      line_resv     <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_cmd       <= '0;
      rsp_offset    <= '0;
      rsp_time      <= '0;
      rsp_data      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (push_ok) begin
            tail  <= tail + 1'b1;
            count <= count + 1'b1;
          end
          if (fill_valid) begin
            line_data     <= fill_data;
            line_valid    <= fill_readable;
            line_writable <= fill_writable;
            line_dirty    <= 1'b0;
            line_resv     <= 1'b0;
            ref_off       <= h_off;
            first_q       <= fill_first_time;
            finish_q      <= fill_finish_time;
            state         <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (count == '0) begin
            state <= S_DONE;
          end else if (is_inv) begin
            line_valid    <= 1'b0;
            line_writable <= 1'b0;
            line_resv     <= 1'b0;
            head          <= head + 1'b1;
            count         <= count - 1'b1;
          end else if (!can_serve) begin
            state <= S_DONE;
          end else begin
            rsp_valid  <= 1'b1;
            rsp_cmd    <= h_cmd;
            rsp_offset <= h_off;
            rsp_time   <= (h_dist == '0) ? first_q : finish_q;
            head       <= head + 1'b1;
            count      <= count - 1'b1;
            if (is_wr) begin
              line_data  <= merged;
              line_dirty <= 1'b1;
              rsp_data   <= '0;
            end else begin
              rsp_data <= rd_word;
              if (h_locked) line_resv <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_one_pop_per_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (tq_count == $past(tq_count) - 1'b1));
  a_r3_time_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_time == first_q || rsp_time == finish_q));
  a_r7_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cmd == CMD_WR) |-> line_dirty);
  a_r6_write_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cmd == CMD_WR) |-> $past(line_writable));
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rsp_valid && !tq_ready));
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tq_count <= FULL_CNT);
endmodule

// File: tb/mshr_target_drain_tb.sv
module mshr_target_drain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 16;
  localparam int WB  = 4;

  logic clk = 0, rst_n = 0;
  logic tq_push = 0, tq_locked = 0;
  logic [1:0] tq_cmd = 0;
  logic [3:0] tq_offset = 0;
  logic [2:0] tq_size = 1;
  logic [31:0] tq_wdata = 0;
  logic tq_ready;
  logic [2:0] tq_count;
  logic fill_valid = 0, fill_readable = 0, fill_writable = 0;
  logic [127:0] fill_data = 0;
  logic [31:0] fill_first_time = 0, fill_finish_time = 0;
  logic rsp_valid;
  logic [1:0] rsp_cmd;
  logic [3:0] rsp_offset;
  logic [31:0] rsp_time, rsp_data;
  logic [127:0] line_data;
  logic line_valid, line_writable, line_dirty, line_resv, done;

  mshr_target_drain u_dut (
    .clk(clk), .rst_n(rst_n), .tq_push(tq_push), .tq_cmd(tq_cmd),
    .tq_locked(tq_locked), .tq_offset(tq_offset), .tq_size(tq_size),
    .tq_wdata(tq_wdata), .tq_ready(tq_ready), .tq_count(tq_count),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .fill_readable(fill_readable), .fill_writable(fill_writable),
    .fill_first_time(fill_first_time), .fill_finish_time(fill_finish_time),
    .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_offset(rsp_offset),
    .rsp_time(rsp_time), .rsp_data(rsp_data), .line_data(line_data),
    .line_valid(line_valid), .line_writable(line_writable),
    .line_dirty(line_dirty), .line_resv(line_resv), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int n_rsp = 0, n_done = 0;
  logic [1:0]  r_cmd  [8];
  logic [3:0]  r_off  [8];
  logic [31:0] r_time [8];
  logic [31:0] r_data [8];

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (n_rsp < 8) begin
        r_cmd[n_rsp] = rsp_cmd; r_off[n_rsp] = rsp_offset;
        r_time[n_rsp] = rsp_time; r_data[n_rsp] = rsp_data;
      end
      n_rsp++;
    end
    if (done) n_done++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic [3:0] off, input logic [2:0] sz,
                      input logic lk, input logic [31:0] wd);
    @(negedge clk);
    tq_push = 1; tq_cmd = c; tq_offset = off; tq_size = sz; tq_locked = lk; tq_wdata = wd;
    @(negedge clk);
    tq_push = 0;
  endtask

  task automatic fill(input logic [127:0] d, input logic rd, input logic wr,
                      input logic [31:0] ft, input logic [31:0] fn);
    @(negedge clk);
    n_rsp = 0; n_done = 0;
    fill_data = d; fill_readable = rd; fill_writable = wr;
    fill_first_time = ft; fill_finish_time = fn; fill_valid = 1;
    @(negedge clk);
    fill_valid = 0;
    for (int k = 0; k < 40 && n_done == 0; k++) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [127:0] mkline(input int seed);
    logic [127:0] l;
    for (int i = 0; i < BLK; i++) l[i*8 +: 8] = 8'((i * 17 + seed) & 255);
    return l;
  endfunction

  logic [127:0] ln;
  logic [31:0] exp_w;
  int sz;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(tq_count == 0 && tq_ready && !rsp_valid && !done, "R11 queue/rsp reset", {tq_count, tq_ready, rsp_valid, done}, 64'h1);
    chk(!line_valid && !line_writable && !line_dirty && !line_resv, "R11 line reset",
        {line_valid, line_writable, line_dirty, line_resv}, 0);
    rst_n = 1;

    // R2 R3 R8 sweep over reference and target offsets
    for (int rf = 0; rf < BLK; rf++) begin
      for (int of = 0; of < BLK; of++) begin
        sz = 1 + (of % WB);
        push(2'd0, 4'(rf), 3'd1, 1'b0, 0);
        push(2'd0, 4'(of), 3'(sz), 1'b0, 0);
        ln = mkline(rf);
        fill(ln, 1, 0, 32'(1000 + rf), 32'(5000 + of * 3));
        exp_w = 0;
        for (int i = 0; i < WB; i++)
          if (i < sz && of + i < BLK) exp_w[i*8 +: 8] = ln[(of+i)*8 +: 8];
        chk(n_rsp == 2, "R4 two responses", n_rsp, 2);
        chk(r_time[0] == 32'(1000 + rf), "R3 head first-word time", r_time[0], 1000 + rf);
        chk(r_time[1] == ((of == rf) ? 32'(1000 + rf) : 32'(5000 + of * 3)), "R2 wrapped distance time",
            r_time[1], (of == rf) ? 1000 + rf : 5000 + of * 3);
        chk(r_data[1] == exp_w, "R8 read bytes", r_data[1], exp_w);
        chk(r_off[0] == 4'(rf) && r_off[1] == 4'(of), "R4 order", {r_off[0], r_off[1]}, {4'(rf), 4'(of)});
      end
    end

    // R7 R9 write merge then locked read
    push(2'd1, 4'd6, 3'd4, 1'b0, 32'hA1B2C3D4);
    push(2'd0, 4'd6, 3'd4, 1'b1, 0);
    push(2'd0, 4'd14, 3'd4, 1'b0, 0);
    ln = mkline(3);
    fill(ln, 1, 1, 32'd77, 32'd99);
    chk(n_rsp == 3, "R4 three responses", n_rsp, 3);
    chk(r_cmd[0] == 2'd1 && r_data[0] == 0, "R7 write rsp no data", r_data[0], 0);
    chk(r_data[1] == 32'hA1B2C3D4, "R7 merged bytes read back", r_data[1], 32'hA1B2C3D4);
    chk(line_data[55:48] == 8'hD4 && line_data[79:72] == 8'hA1, "R7 line byte lanes", line_data[79:48], 32'hA1B2C3D4);
    chk(line_data[47:0] == ln[47:0], "R7 untouched bytes", line_data[47:0], ln[47:0]);
    chk(line_dirty, "R7 dirty set", line_dirty, 1);
    chk(line_resv, "R9 reservation set", line_resv, 1);
    chk(r_time[0] == 77 && r_time[1] == 77 && r_time[2] == 99, "R3 times", r_time[2], 99);
    chk(r_data[2] == {16'h0, ln[127:112]}, "R8 zero beyond line end", r_data[2], {16'h0, ln[127:112]});
    chk(tq_count == 0 && n_done == 1, "R10 single done pulse", n_done, 1);

    // R5 R6 invalidate mid-walk
    push(2'd0, 4'd2, 3'd1, 1'b0, 0);
    push(2'd2, 4'd0, 3'd1, 1'b0, 0);
    push(2'd0, 4'd3, 3'd1, 1'b0, 0);
    push(2'd3, 4'd4, 3'd1, 1'b0, 0);
    fill(mkline(9), 1, 1, 32'd10, 32'd20);
    chk(n_rsp == 1, "R5 no rsp for invalidate", n_rsp, 1);
    chk(!line_valid && !line_writable && !line_resv, "R5 line killed", {line_valid, line_writable}, 0);
    chk(!line_dirty, "R10 fill clears dirty", line_dirty, 0);
    chk(tq_count == 2, "R6 remaining stay queued", tq_count, 2);
    chk(tq_ready, "R10 idle accepts again", tq_ready, 1);

    // R6 R2 leftovers served by next refill, read-only line; code 3 acts as read
    fill(mkline(1), 1, 0, 32'd30, 32'd40);
    chk(n_rsp == 2 && r_off[0] == 3 && r_off[1] == 4, "R6 leftovers in order", {r_off[0], r_off[1]}, 8'h34);
    chk(r_time[0] == 30 && r_time[1] == 40, "R2 reference is new head", r_time[1], 40);
    chk(r_cmd[1] == 2'd3 && r_data[1][7:0] == mkline(1)[39:32], "R5 code 3 read", r_data[1], mkline(1)[39:32]);
    chk(!line_resv, "R9 refill clears reservation", line_resv, 0);

    // R6 write without permission stops
    push(2'd1, 4'd0, 3'd2, 1'b0, 32'h55AA);
    push(2'd0, 4'd1, 3'd1, 1'b0, 0);
    fill(mkline(2), 1, 0, 32'd1, 32'd2);
    chk(n_rsp == 0 && tq_count == 2 && n_done == 1, "R6 write needs writable", {n_rsp, tq_count}, 2);
    chk(line_data == mkline(2) && !line_dirty, "R6 line untouched", line_dirty, 0);
    fill(mkline(2), 1, 1, 32'd1, 32'd2);
    chk(n_rsp == 2 && tq_count == 0, "R6 drains when writable", tq_count, 0);
    chk(line_data[15:0] == 16'h55AA, "R7 two-byte write", line_data[15:0], 16'h55AA);

    // R1 full queue and busy drops
    for (int i = 0; i < 5; i++) push(2'd0, 4'(i), 3'd1, 1'b0, 0);
    chk(tq_count == 4 && !tq_ready, "R1 full queue", tq_count, 4);
    @(negedge clk);
    n_rsp = 0; n_done = 0;
    fill_data = mkline(5); fill_readable = 1; fill_writable = 0;
    fill_first_time = 5; fill_finish_time = 6; fill_valid = 1;
    chk(!tq_ready, "R1 not ready during fill", tq_ready, 0);
    @(negedge clk);
    fill_valid = 0; tq_push = 1; tq_cmd = 0; tq_offset = 4'd9;
    chk(!tq_ready, "R1 not ready while draining", tq_ready, 0);
    @(negedge clk);
    tq_push = 0;
    for (int k = 0; k < 40 && n_done == 0; k++) @(posedge clk);
    @(negedge clk);
    chk(n_rsp == 4 && tq_count == 0, "R1 busy push dropped", {n_rsp, tq_count}, 64'h40);
    chk(r_off[3] == 3, "R4 fifth push never entered", r_off[3], 3);

    // R10 refill on empty queue
    fill(mkline(8), 1, 1, 32'd3, 32'd4);
    chk(n_rsp == 0 && n_done == 1 && line_data == mkline(8) && line_valid, "R10 empty refill", n_rsp, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule